// File: doc/BRIEF.md
# Streaming Slice Matrix Multiplier

This block forms the product of a tall square matrix A (N×N) and a narrow matrix S (N×NB) with all arithmetic modulo 2^16. A is produced elsewhere and reaches the block in slices of four rows. Those rows are written into four row buffers. S is written once into a resident buffer and serves every slice. A single write port of 32-bit words fills both the row buffers and S, with two 16-bit elements packed into each word.

A start pulse begins one pass over the four buffered rows. The pass sweeps the NB columns of S. For each column it streams the N/2 packed words and runs eight 16-bit multiply-accumulates per cycle, then writes four results, one per lane bank. The block keeps a count of finished passes, so pass p fills result rows 4p to 4p+3. Once N/4 passes have finished, the full N×NB result is read back through a 32-bit read port, two results per word.

Top module: `stream_lmul`

## Requirements
- R1: Every result element equals the sum over k of A[i][k]·S[k][j], truncated to 16 bits, with all intermediate wrap ignored. For example, with every A and S element 0xFFFF and N=16, each result is 0x0010.
- R2: A write with wr_to_s=0 goes to a row buffer. Row slot = wr_addr[1:0], word index = wr_addr>>2. The low half of wr_data holds element 2·word and the high half holds element 2·word+1 of that slot's row.
- R3: A write with wr_to_s=1 goes to S at word c·(N/2)+w. The low half holds S[2w][c] and the high half holds S[2w+1][c]. Any S write returns the pass index to 0.
- R4: A start in idle, with fewer than N/4 passes finished, runs pass p (the current pass index). That pass writes result rows 4p+slot from row slot 0..3 and leaves all other rows unchanged. The pass index then advances by one.
- R5: busy is 1 from the cycle after an accepted start until the pass ends. When the pass ends, done is 1 for exactly one cycle and busy is 0 in that same cycle. A pass lasts no more than NB·N/2+4 cycles.
- R6: A start while busy has no effect: no extra pass, no extra done, and the results are unchanged.
- R7: S is loaded once and stays in place. All N/4 passes give correct results with no S reload between them.
- R8: Read word w returns result rows and columns as follows: bits [15:0] = B[w/(NB/2)][2·(w mod NB/2)] and bits [31:16] = the next column. rd_data shows the word for the rd_addr sampled at the previous rising edge.
- R9: After reset, busy=0, done=0, rd_data=0 and the pass index is 0.
- R10: A start after all N/4 passes have finished is ignored: busy stays 0, done does not pulse, and the results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_to_s | input | 1 | 1 selects the S buffer, 0 selects the row buffers |
| wr_addr | input | clog2(N·NB/2) | Word address of the write |
| wr_data | input | 32 | Two packed 16-bit elements |
| start | input | 1 | Begin one four-row pass |
| busy | output | 1 | A pass is running |
| done | output | 1 | One-cycle pulse at the end of a pass |
| rd_addr | input | clog2(N·NB/2) | Result word address |
| rd_data | output | 32 | Two adjacent results, lower column in low half |

## Verification
Matrices with every element at 0xFFFF make each product equal 1 after wrap. The result then shows whether truncation is done per product and per sum, rather than any saturation or sign handling. Random A and S over four passes with no reload of S check the packing of both buffers, lane-to-bank steering and row placement per pass. Any swap of halves, lanes or columns gives a wrong value. A third run writes a new S and a single new slice. Only rows 0..3 may change in that run, which separates a correct pass-index reset from rows being written in the wrong place. Extra start pulses during a pass and after the last pass must leave both done and the stored results unchanged.

// File: rtl/stream_lmul_pkg.sv
package stream_lmul_pkg;
    localparam int ELEM_W = 16;
    localparam int WORD_W = 32;

    typedef logic [ELEM_W-1:0] elem_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

    // tag travelling with each fetched word pair
    typedef struct packed {
        logic vld;   // fetched data valid this cycle
        logic last;  // final word of a column
        logic fin;   // final word of the pass
    } fetch_tag_t;

    // two 16-bit products of packed halves, summed modulo 2^16
    function automatic elem_t mac_pair(word_t a, word_t s);
        elem_t p0;
        elem_t p1;
        p0 = a[15:0] * s[15:0];
        p1 = a[31:16] * s[31:16];
        return p0 + p1;
    endfunction
endpackage

// File: rtl/stream_lmul_aslice.sv
module stream_lmul_aslice
    import stream_lmul_pkg::*;
#(
    parameter int LANES = 4,
    parameter int KW    = 320,
    parameter int KAW   = $clog2(KW)
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [KAW-1:0]          waddr,
    input  word_t                   wdata,
    input  logic [KAW-1:0]          raddr,
    output logic [LANES-1:0][31:0]  rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_row
        word_t mem [KW];
        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata;
            rdata[g] <= mem[raddr];
        end
    end
endmodule

// File: rtl/stream_lmul_sstore.sv
module stream_lmul_sstore
    import stream_lmul_pkg::*;
#(
    parameter int SW  = 2560,
    parameter int SAW = $clog2(SW)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [SAW-1:0] waddr,
    input  word_t          wdata,
    input  logic [SAW-1:0] raddr,
    output word_t          rdata
);
    word_t mem [SW];
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/stream_lmul_lane.sv
module stream_lmul_lane
    import stream_lmul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t a_word,
    input  word_t s_word,
    input  logic  vld,
    input  logic  last,
    output elem_t sum_now
);
    elem_t acc;

    assign sum_now = acc + mac_pair(a_word, s_word);

    // the sum at the final word goes to the bank; the next column starts from zero
    always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (vld)  acc <= last ? '0 : sum_now;
    end
endmodule

// File: rtl/stream_lmul_bank.sv
module stream_lmul_bank
    import stream_lmul_pkg::*;
#(
    parameter int BD  = 1280,
    parameter int BAW = $clog2(BD)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [BAW-1:0] waddr,
    input  elem_t          wdata,
    input  logic [BAW-1:0] raddr0,
    input  logic [BAW-1:0] raddr1,
    output elem_t          rdata0,
    output elem_t          rdata1
);
    elem_t mem [BD];
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end
    assign rdata0 = mem[raddr0];
    assign rdata1 = mem[raddr1];
endmodule

// File: rtl/stream_lmul.sv
module stream_lmul
    import stream_lmul_pkg::*;
#(
    parameter  int N     = 640,
    parameter  int NB    = 8,
    parameter  int LANES = 4,
    localparam int AW    = $clog2(N*NB/2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_to_s,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          start,
    output logic          busy,
    output logic          done,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data
);
    localparam int KW  = N / 2;
    localparam int KAW = $clog2(KW);
    localparam int SW  = NB * KW;
    localparam int SAW = $clog2(SW);
    localparam int NP  = N / LANES;
    localparam int PW  = $clog2(NP + 1);
    localparam int BD  = NP * NB;
    localparam int BAW = $clog2(BD);
    localparam int LW  = $clog2(LANES);
    localparam int CW  = $clog2(NB);
    localparam int JW  = $clog2(NB / 2);
    localparam int IW  = AW - JW;

    run_state_e        state;
    logic [PW-1:0]     pass_cnt;
    logic [CW-1:0]     col, col_q;
    logic [KAW-1:0]    kw;
    logic              iss_on;
    fetch_tag_t        tag;

    logic              s_wr, start_ok, bank_we;
    logic [LANES-1:0]  a_we;
    logic [LW-1:0]     a_slot;
    logic [KAW-1:0]    a_waddr;
    logic [SAW-1:0]    s_raddr;
    logic [BAW-1:0]    bank_waddr;

    logic [LANES-1:0][31:0] a_rd;
    word_t                  s_rd;
    elem_t                  lane_sum [LANES];
    elem_t                  brd0 [LANES];
    elem_t                  brd1 [LANES];

    logic [IW-1:0]     rd_row;
    logic [JW-1:0]     rd_pair;
    logic [LW-1:0]     rd_bank;
    logic [BAW-1:0]    rd_a0, rd_a1;

    assign busy     = (state == ST_RUN);
    assign s_wr     = wr_en && wr_to_s;
    assign start_ok = start && !busy && (int'(pass_cnt) < NP);

    // write decode: row slot in the low address bits, word index above
    assign a_slot  = wr_addr[LW-1:0];
    assign a_waddr = KAW'(wr_addr >> LW);
    assign a_we    = (wr_en && !wr_to_s) ? (LANES'(1) << a_slot) : '0;

    // fetch address: S is column-major by packed word
    assign s_raddr = SAW'(int'(col) * KW + int'(kw));

    stream_lmul_aslice #(.LANES(LANES), .KW(KW), .KAW(KAW)) u_aslice (
        .clk   (clk),
        .we    (a_we),
        .waddr (a_waddr),
        .wdata (wr_data),
        .raddr (kw),
        .rdata (a_rd)
    );

    stream_lmul_sstore #(.SW(SW), .SAW(SAW)) u_sstore (
        .clk   (clk),
        .we    (s_wr),
        .waddr (SAW'(wr_addr)),
        .wdata (wr_data),
        .raddr (s_raddr),
        .rdata (s_rd)
    );

    assign bank_we    = tag.vld && tag.last;
    assign bank_waddr = BAW'(int'(pass_cnt) * NB + int'(col_q));

    // readback decode: row, pair within row, bank = row mod LANES
    assign rd_row  = rd_addr[AW-1:JW];
    assign rd_pair = rd_addr[JW-1:0];
    assign rd_bank = rd_row[LW-1:0];
    assign rd_a0   = BAW'(int'(rd_row >> LW) * NB + 2 * int'(rd_pair));
    assign rd_a1   = rd_a0 + BAW'(1);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        stream_lmul_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .a_word  (a_rd[g]),
            .s_word  (s_rd),
            .vld     (tag.vld),
            .last    (tag.last),
            .sum_now (lane_sum[g])
        );
        stream_lmul_bank #(.BD(BD), .BAW(BAW)) u_bank (
            .clk    (clk),
            .we     (bank_we),
            .waddr  (bank_waddr),
            .wdata  (lane_sum[g]),
            .raddr0 (rd_a0),
            .raddr1 (rd_a1),
            .rdata0 (brd0[g]),
            .rdata1 (brd1[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= {brd1[rd_bank], brd0[rd_bank]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pass_cnt <= '0;
            col      <= '0;
            col_q    <= '0;
            kw       <= '0;
            iss_on   <= 1'b0;
            tag      <= '0;
            done     <= 1'b0;
        end else begin
            done     <= 1'b0;
            col_q    <= col;
            tag.vld  <= iss_on;
            tag.last <= iss_on && (kw == KAW'(KW - 1));
            tag.fin  <= iss_on && (kw == KAW'(KW - 1)) && (col == CW'(NB - 1));
            if (iss_on) begin
                if (kw == KAW'(KW - 1)) begin
                    kw <= '0;
                    if (col == CW'(NB - 1)) begin
                        col    <= '0;
                        iss_on <= 1'b0;
                    end else begin
                        col <= col + CW'(1);
                    end
                end else begin
                    kw <= kw + KAW'(1);
                end
            end
            if (start_ok) begin
                state  <= ST_RUN;
                iss_on <= 1'b1;
            end
            if (tag.vld && tag.fin) begin
                state    <= ST_IDLE;
                done     <= 1'b1;
                pass_cnt <= pass_cnt + PW'(1);
            end
            if (s_wr) pass_cnt <= '0;
        end
    end

    // R5: done lasts a single cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R5: the end-of-pass pulse coincides with idle
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R6: a start during a pass does not cut it short
    a_r6_start_busy: assert property (@(posedge clk) disable iff (rst)
        busy && start && !(tag.vld && tag.fin) |=> busy);
    // R3: an S write returns the pass index to zero
    a_r3_s_rewinds: assert property (@(posedge clk) disable iff (rst)
        s_wr |=> pass_cnt == '0);
    // R10: the pass index never passes the row count
    a_r10_pass_bound: assert property (@(posedge clk) disable iff (rst)
        int'(pass_cnt) <= NP);
    // R10: start is refused once every pass is finished
    a_r10_full_refuse: assert property (@(posedge clk) disable iff (rst)
        !busy && start && int'(pass_cnt) == NP && !s_wr |=> !busy);
    // R4: result banks are written only during a pass
    a_r4_bank_in_pass: assert property (@(posedge clk) disable iff (rst)
        bank_we |-> busy);
endmodule

// File: tb/sim_stream_lmul.sv
module sim_stream_lmul;
    localparam int N   = 16;
    localparam int NB  = 8;
    localparam int AW  = $clog2(N*NB/2);
    localparam int KW  = N / 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, wr_to_s, start;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [31:0]   wr_data;
    logic          busy, done;
    logic [31:0]   rd_data;

    logic [15:0] am  [N][N];
    logic [15:0] sm  [N][NB];
    logic [15:0] exb [N][NB];

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    stream_lmul #(.N(N), .NB(NB), .LANES(4)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_to_s(wr_to_s),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
        .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    function automatic logic [15:0] dot(int r, int c);
        logic [15:0] acc = '0;
        for (int k = 0; k < N; k++) acc = acc + 16'(am[r][k] * sm[k][c]);
        return acc;
    endfunction

    task automatic wr_word(input logic sel, input int addr, input logic [31:0] d);
        wr_en = 1'b1; wr_to_s = sel; wr_addr = AW'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R3: S word c*(N/2)+w = {S[2w+1][c], S[2w][c]}
    task automatic load_s();
        for (int c = 0; c < NB; c++)
            for (int w = 0; w < KW; w++)
                wr_word(1'b1, c*KW + w, {sm[2*w+1][c], sm[2*w][c]});
    endtask

    // R2: A word w*4+slot = {A[r][2w+1], A[r][2w]}
    task automatic load_a(input int p);
        for (int slot = 0; slot < 4; slot++)
            for (int w = 0; w < KW; w++)
                wr_word(1'b0, w*4 + slot, {am[4*p+slot][2*w+1], am[4*p+slot][2*w]});
    endtask

    task automatic run_pass(input int p, input bit extra);
        bit seen = 0;
        int dcount = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R5 busy after start", {31'd0, busy}, 32'd1);
        for (int t = 0; t < NB*KW + 4 && !seen; t++) begin
            start = (extra && t == 10);
            @(negedge clk);
            if (done) seen = 1;
        end
        start = 1'b0;
        chk("R5 done within bound", {31'd0, seen}, 32'd1);
        chk("R5 busy low at done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R5 done one cycle", {31'd0, done}, 32'd0);
        if (extra) begin
            for (int t = 0; t < NB*KW + 16; t++) begin
                @(negedge clk);
                if (done) dcount++;
            end
            chk("R6 no extra done", dcount, 0);
            chk("R6 idle after extra start", {31'd0, busy}, 32'd0);
        end
        for (int r = 4*p; r < 4*p + 4; r++)
            for (int c = 0; c < NB; c++) exb[r][c] = dot(r, c);
    endtask

    // R8: word w = {B[w/4][2(w%4)+1], B[w/4][2(w%4)]}
    task automatic check_all(input string req);
        for (int w = 0; w < N*NB/2; w++) begin
            rd_addr = AW'(w);
            @(negedge clk);
            chk(req, rd_data, {exb[w/4][2*(w%4)+1], exb[w/4][2*(w%4)]});
        end
    endtask

    initial begin
        int dcount;
        rst = 1'b1; wr_en = 1'b0; wr_to_s = 1'b0; start = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        chk("R9 busy reset", {31'd0, busy}, 32'd0);
        chk("R9 done reset", {31'd0, done}, 32'd0);
        chk("R9 rd_data reset", rd_data, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1: all 0xFFFF -> each product wraps to 1, sum of N = 16
        for (int i = 0; i < N; i++) for (int k = 0; k < N; k++) am[i][k] = 16'hFFFF;
        for (int k = 0; k < N; k++) for (int c = 0; c < NB; c++) sm[k][c] = 16'hFFFF;
        load_s();
        for (int p = 0; p < N/4; p++) begin load_a(p); run_pass(p, 0); end
        for (int r = 0; r < N; r++) for (int c = 0; c < NB; c++)
            if (exb[r][c] !== 16'h0010) begin
                failures++;
                $display("FAIL R1 bench model actual=%h expected=0010", exb[r][c]);
            end
        check_all("R1 wrap");

        // R7/R2/R8: random data, S written once, four passes
        for (int i = 0; i < N; i++) for (int k = 0; k < N; k++) am[i][k] = 16'($urandom());
        for (int k = 0; k < N; k++) for (int c = 0; c < NB; c++) sm[k][c] = 16'($urandom());
        load_s();
        for (int p = 0; p < N/4; p++) begin load_a(p); run_pass(p, p == 0); end
        check_all("R7 multi-pass random");

        // R10: start after all passes is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy stays low", {31'd0, busy}, 32'd0);
        dcount = 0;
        for (int t = 0; t < NB*KW + 8; t++) begin
            @(negedge clk);
            if (done) dcount++;
        end
        chk("R10 no done", dcount, 0);
        check_all("R10 results kept");

        // R3/R4: new S rewinds pass index; only rows 0..3 change
        for (int k = 0; k < N; k++) for (int c = 0; c < NB; c++) sm[k][c] = 16'($urandom());
        sm[0][0] = 16'hFFFF; sm[N-1][NB-1] = 16'h0000;
        for (int r = 0; r < 4; r++) for (int k = 0; k < N; k++) am[r][k] = 16'($urandom());
        load_s();
        load_a(0);
        run_pass(0, 0);
        check_all("R4 single pass rows 0..3");

        summary();
        $finish;
    end
endmodule